// File: doc/BRIEF.md
# Macro-op atomic commit gate

This block sits at the head of a reorder buffer whose entries are micro-operations. Several micro-operations may together make up one architectural instruction. The first of them carries a start marker and the last carries an end marker. The gate looks at a parallel view of the oldest window entries, starting at the head. Each cycle it decides whether the whole head instruction may retire as one unit. If it may, the gate reports how many entries to pop. If the instruction cannot yet retire, the gate holds it back. If the instruction carries a fault, the gate raises a flush and an exception-taken indication instead of retiring it.

The gate also keeps the architectural instruction pointer. A retiring group that contains a control-transfer micro-operation loads that operation's target into the pointer. Any other retiring group moves the pointer forward by its byte length. A pending external interrupt is accepted only on the cycle that follows a completed retirement, which is always an instruction boundary.

The decision outputs (commit count, flush, exception) are combinational from the window. The pointer and the interrupt-accept pulse are registered, so their new values are visible one clock edge after the retiring cycle.

Top module: `mop_commit_gate`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `commit_cnt`, `flush_o`, `exc_o` and `irq_ack_o` are 0, and `ip_o` equals `reset_vector`.
- R2: The head group runs from window entry 0, which must be valid with bit `win_som[0]` set, through the first valid entry with its `win_eom` bit set. If every entry of the group has `win_rdy` set and none has `win_exc` set, `commit_cnt` equals the group size in the same cycle. The group size ranges from 1 to WIN.
- R3: If any entry of a complete head group has `win_rdy` clear and none has `win_exc` set, `commit_cnt` is 0 and `flush_o` is 0.
- R4: The scan for the end marker stops at the first entry whose `win_valid` bit is clear. If no end marker is seen before that point or before the window ends, the gate waits: `commit_cnt` is 0 and `flush_o` is 0.
- R5: If any entry of a complete head group has `win_exc` set, `flush_o` and `exc_o` are 1 and `commit_cnt` is 0. An exception bit on an entry beyond the group's end marker has no effect.
- R6: An entry with both `win_som` and `win_eom` set is a one-entry instruction. It retires with `commit_cnt` equal to 1 as soon as its own `win_rdy` bit is set.
- R7: `irq_ack_o` is 1 for exactly the cycle after a cycle in which `irq_req` was high and `commit_cnt` was non-zero. It stays 0 after cycles that waited or flushed.
- R8: After a retiring cycle, `ip_o` equals the `win_tgt` field of the highest-numbered group entry with `win_br` set. If no group entry has `win_br` set, `ip_o` equals the old pointer plus entry 0's 4-bit `win_len` field (legal values 1 to 15). Entry i's length is `win_len[4i+3:4i]` and its target is `win_tgt[IPW*i+IPW-1:IPW*i]`.
- R9: If entry 0 is valid but has `win_som` clear, the gate waits with `commit_cnt` at 0 and `flush_o` at 0.
- R10: `ip_o` changes only after a retiring cycle. Flushes and waits leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_vector | input | IPW | Pointer value loaded during reset |
| win_valid | input | WIN | Entry i holds a micro-operation |
| win_som | input | WIN | Start-of-instruction marker per entry |
| win_eom | input | WIN | End-of-instruction marker per entry |
| win_rdy | input | WIN | Entry has finished execution |
| win_exc | input | WIN | Entry raised a fault |
| win_br | input | WIN | Entry is a control transfer |
| win_len | input | 4*WIN | Instruction byte length per entry |
| win_tgt | input | IPW*WIN | Control-transfer target per entry |
| irq_req | input | 1 | Pending external interrupt |
| commit_cnt | output | $clog2(WIN+1) | Entries to pop this cycle |
| flush_o | output | 1 | Pipeline flush request |
| exc_o | output | 1 | Exception taken |
| irq_ack_o | output | 1 | Interrupt accepted at a boundary |
| ip_o | output | IPW | Architectural instruction pointer |

## Verification
Retirement and interrupt acceptance can happen together. Retirement and the pointer update also happen together: one retiring group both pops entries and moves the pointer. The bench provokes this by raising `irq_req` in a cycle where a ready group is at the head. In the same transaction it checks the pop count, the redirected or advanced pointer, and the accept pulse one edge later. Contrast cases hold `irq_req` high during a wait and during a flush, where the accept pulse must stay low and the pointer must not move.

// File: rtl/mcg_pkg.sv
package mcg_pkg;

    localparam int LEN_W = 4;

    typedef enum logic [1:0] {
        GATE_WAIT   = 2'd0,
        GATE_RETIRE = 2'd1,
        GATE_FLUSH  = 2'd2
    } gate_e;

    typedef struct packed {
        logic all_rdy;
        logic any_exc;
        logic any_br;
    } grp_sum_t;

    // A fault wins over readiness; an incomplete or unstarted group waits.
    function automatic gate_e decide(input logic head_ok, input grp_sum_t s);
        if (!head_ok)      return GATE_WAIT;
        else if (s.any_exc) return GATE_FLUSH;
        else if (s.all_rdy) return GATE_RETIRE;
        else               return GATE_WAIT;
    endfunction

endpackage

// File: rtl/mcg_end_scan.sv
module mcg_end_scan #(
    parameter int WIN   = 8,
    parameter int IDX_W = $clog2(WIN)
) (
    input  logic [WIN-1:0]   valid,
    input  logic [WIN-1:0]   eom,
    output logic             found,
    output logic [IDX_W-1:0] last_idx,
    output logic [WIN-1:0]   mask
);

    always_comb begin
        logic stop;
        stop     = 1'b0;
        found    = 1'b0;
        last_idx = '0;
        mask     = '0;
        for (int i = 0; i < WIN; i++) begin
            if (!stop) begin
                if (!valid[i]) begin
                    stop = 1'b1;
                end else begin
                    mask[i] = 1'b1;
                    if (eom[i]) begin
                        found    = 1'b1;
                        last_idx = IDX_W'(i);
                        stop     = 1'b1;
                    end
                end
            end
        end
        if (!found) mask = '0;
    end

endmodule

// File: rtl/mcg_group_eval.sv
module mcg_group_eval
    import mcg_pkg::*;
#(
    parameter int WIN = 8,
    parameter int IPW = 32
) (
    input  logic [WIN-1:0]     mask,
    input  logic [WIN-1:0]     rdy,
    input  logic [WIN-1:0]     exc,
    input  logic [WIN-1:0]     br,
    input  logic [WIN*IPW-1:0] tgt_flat,
    output grp_sum_t           sum,
    output logic [IPW-1:0]     br_tgt
);

    logic [IPW-1:0] tgt_arr [WIN];

    genvar g;
    generate
        for (g = 0; g < WIN; g++) begin : g_unpack
            assign tgt_arr[g] = tgt_flat[g*IPW +: IPW];
        end
    endgenerate

    always_comb begin
        sum.all_rdy = &(rdy | ~mask);
        sum.any_exc = |(exc & mask);
        sum.any_br  = |(br & mask);
    end

    // Youngest control transfer in the group decides the next pointer.
    always_comb begin
        br_tgt = '0;
        for (int i = 0; i < WIN; i++) begin
            if (mask[i] && br[i]) br_tgt = tgt_arr[i];
        end
    end

endmodule

// File: rtl/mcg_ip_track.sv
module mcg_ip_track
    import mcg_pkg::*;
#(
    parameter int IPW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IPW-1:0]   reset_vector,
    input  logic             retire,
    input  logic             use_br,
    input  logic [IPW-1:0]   br_tgt,
    input  logic [LEN_W-1:0] head_len,
    input  logic             irq_req,
    output logic [IPW-1:0]   ip_o,
    output logic             irq_ack_o
);

    logic [IPW-1:0] ip_next;

    always_comb begin
        ip_next = ip_o;
        if (retire) begin
            if (use_br) ip_next = br_tgt;
            else        ip_next = ip_o + {{(IPW-LEN_W){1'b0}}, head_len};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ip_o      <= reset_vector;
            irq_ack_o <= 1'b0;
        end else begin
            ip_o      <= ip_next;
            irq_ack_o <= retire & irq_req;
        end
    end

endmodule

// File: rtl/mop_commit_gate.sv
module mop_commit_gate
    import mcg_pkg::*;
#(
    parameter int WIN = 8,
    parameter int IPW = 32,
    localparam int IDX_W = $clog2(WIN),
    localparam int CNT_W = $clog2(WIN + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IPW-1:0]       reset_vector,
    input  logic [WIN-1:0]       win_valid,
    input  logic [WIN-1:0]       win_som,
    input  logic [WIN-1:0]       win_eom,
    input  logic [WIN-1:0]       win_rdy,
    input  logic [WIN-1:0]       win_exc,
    input  logic [WIN-1:0]       win_br,
    input  logic [WIN*LEN_W-1:0] win_len,
    input  logic [WIN*IPW-1:0]   win_tgt,
    input  logic                 irq_req,
    output logic [CNT_W-1:0]     commit_cnt,
    output logic                 flush_o,
    output logic                 exc_o,
    output logic                 irq_ack_o,
    output logic [IPW-1:0]       ip_o
);

    logic             found;
    logic [IDX_W-1:0] last_idx;
    logic [WIN-1:0]   grp_mask;
    grp_sum_t         sum;
    logic [IPW-1:0]   br_tgt;
    logic             head_ok;
    gate_e            verdict;
    logic             retire;

    mcg_end_scan #(.WIN(WIN), .IDX_W(IDX_W)) u_scan (
        .valid    (win_valid),
        .eom      (win_eom),
        .found    (found),
        .last_idx (last_idx),
        .mask     (grp_mask)
    );

    mcg_group_eval #(.WIN(WIN), .IPW(IPW)) u_eval (
        .mask     (grp_mask),
        .rdy      (win_rdy),
        .exc      (win_exc),
        .br       (win_br),
        .tgt_flat (win_tgt),
        .sum      (sum),
        .br_tgt   (br_tgt)
    );

    assign head_ok = found & win_valid[0] & win_som[0];
    assign verdict = rst ? GATE_WAIT : decide(head_ok, sum);
    assign retire  = (verdict == GATE_RETIRE);

    assign commit_cnt = retire ? (CNT_W'(last_idx) + CNT_W'(1)) : '0;
    assign flush_o    = (verdict == GATE_FLUSH);
    assign exc_o      = (verdict == GATE_FLUSH);

    mcg_ip_track #(.IPW(IPW)) u_ip (
        .clk          (clk),
        .rst          (rst),
        .reset_vector (reset_vector),
        .retire       (retire),
        .use_br       (sum.any_br),
        .br_tgt       (br_tgt),
        .head_len     (win_len[LEN_W-1:0]),
        .irq_req      (irq_req),
        .ip_o         (ip_o),
        .irq_ack_o    (irq_ack_o)
    );

endmodule

// File: rtl/mop_commit_gate_chk.sv
module mop_commit_gate_chk #(
    parameter int WIN   = 8,
    parameter int IPW   = 32,
    parameter int CNT_W = $clog2(WIN + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [IPW-1:0]   reset_vector,
    input logic [WIN-1:0]   win_valid,
    input logic [WIN-1:0]   win_som,
    input logic             irq_req,
    input logic [CNT_W-1:0] commit_cnt,
    input logic             flush_o,
    input logic             irq_ack_o,
    input logic [IPW-1:0]   ip_o
);

    localparam logic [CNT_W-1:0] MAXC = CNT_W'(WIN);

    // R1
    reset_load_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ip_o == reset_vector) && !irq_ack_o);

    // R2
    retire_head_chk: assert property (@(posedge clk) disable iff (rst)
        (commit_cnt != '0) |-> (win_valid[0] && win_som[0]));

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        commit_cnt <= MAXC);

    // R5
    flush_excl_chk: assert property (@(posedge clk) disable iff (rst)
        flush_o |-> (commit_cnt == '0) && win_valid[0] && win_som[0]);

    // R7
    irq_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        irq_ack_o |-> ($past(irq_req) && ($past(commit_cnt) != '0)));

    // R10
    ip_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(commit_cnt) == '0) |-> $stable(ip_o));

endmodule

bind mop_commit_gate mop_commit_gate_chk #(.WIN(WIN), .IPW(IPW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .reset_vector (reset_vector),
    .win_valid    (win_valid),
    .win_som      (win_som),
    .irq_req      (irq_req),
    .commit_cnt   (commit_cnt),
    .flush_o      (flush_o),
    .irq_ack_o    (irq_ack_o),
    .ip_o         (ip_o)
);

// File: tb/sim_mop_commit_gate.sv
`timescale 1ns/1ps
module sim_mop_commit_gate;

    localparam int WIN = 8;
    localparam int IPW = 32;
    localparam int CNT_W = $clog2(WIN + 1);
    localparam logic [IPW-1:0] RV = 32'h0000_4000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [IPW-1:0]     reset_vector = RV;
    logic [WIN-1:0]     win_valid = '0, win_som = '0, win_eom = '0;
    logic [WIN-1:0]     win_rdy = '0, win_exc = '0, win_br = '0;
    logic [WIN*4-1:0]   win_len = '0;
    logic [WIN*IPW-1:0] win_tgt;
    logic               irq_req = 1'b0;
    logic [CNT_W-1:0]   commit_cnt;
    logic               flush_o, exc_o, irq_ack_o;
    logic [IPW-1:0]     ip_o;

    always #2.5 clk = ~clk;

    mop_commit_gate #(.WIN(WIN), .IPW(IPW)) u0 (
        .clk(clk), .rst(rst), .reset_vector(reset_vector),
        .win_valid(win_valid), .win_som(win_som), .win_eom(win_eom),
        .win_rdy(win_rdy), .win_exc(win_exc), .win_br(win_br),
        .win_len(win_len), .win_tgt(win_tgt), .irq_req(irq_req),
        .commit_cnt(commit_cnt), .flush_o(flush_o), .exc_o(exc_o),
        .irq_ack_o(irq_ack_o), .ip_o(ip_o)
    );

    typedef struct {
        int       cnt;
        bit       flush;
        bit       ack;
        logic [IPW-1:0] ip;
        string    tag;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    logic [IPW-1:0] mdl_ip;

    function automatic logic [IPW-1:0] tgt_of(input int i);
        return 32'h0002_0000 + 32'(i) * 32'h100;
    endfunction

    initial begin
        for (int i = 0; i < WIN; i++) win_tgt[i*IPW +: IPW] = tgt_of(i);
    end

    // Driver: drives one window per cycle and predicts the result.
    task automatic apply(input logic [7:0] v, input logic [7:0] s,
                         input logic [7:0] e, input logic [7:0] r,
                         input logic [7:0] x, input logic [7:0] b,
                         input logic [3:0] len0, input logic irq,
                         input string tag);
        exp_t it;
        int   end_at;
        bit   blocked, got_exc, all_r, any_b;
        logic [IPW-1:0] bt;
        @(negedge clk);
        win_valid = v; win_som = s; win_eom = e; win_rdy = r;
        win_exc = x; win_br = b; irq_req = irq;
        win_len = '0;
        win_len[3:0] = len0;
        for (int i = 1; i < WIN; i++) win_len[i*4 +: 4] = 4'd2;
        end_at = -1; blocked = 0;
        for (int i = 0; i < WIN; i++) begin
            if (end_at < 0 && !blocked) begin
                if (!v[i]) blocked = 1;
                else if (e[i]) end_at = i;
            end
        end
        got_exc = 0; all_r = 1; any_b = 0; bt = '0;
        for (int i = 0; i <= end_at; i++) begin
            if (x[i]) got_exc = 1;
            if (!r[i]) all_r = 0;
            if (b[i]) begin any_b = 1; bt = tgt_of(i); end
        end
        it.cnt = 0; it.flush = 0; it.ack = 0; it.tag = tag;
        if (end_at >= 0 && v[0] && s[0]) begin
            if (got_exc) it.flush = 1;
            else if (all_r) begin
                it.cnt = end_at + 1;
                it.ack = irq;
                mdl_ip = any_b ? bt : mdl_ip + {28'd0, len0};
            end
        end
        it.ip = mdl_ip;
        q.push_back(it);
    endtask

    // Monitor: after each edge, compare against the oldest prediction.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                n_vec++;
                if (int'(commit_cnt) != it.cnt || flush_o != it.flush ||
                    exc_o != it.flush || irq_ack_o != it.ack || ip_o != it.ip) begin
                    n_bad++;
                    $display("FAIL %s: cnt=%0d flush=%0b exc=%0b ack=%0b ip=%h exp cnt=%0d flush=%0b exc=%0b ack=%0b ip=%h",
                             it.tag, commit_cnt, flush_o, exc_o, irq_ack_o, ip_o,
                             it.cnt, it.flush, it.flush, it.ack, it.ip);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        mdl_ip = RV;
        // R1: a retirable window and a pending interrupt during reset
        win_valid = 8'h01; win_som = 8'h01; win_eom = 8'h01; win_rdy = 8'h01;
        win_len[3:0] = 4'd3; irq_req = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (commit_cnt != '0 || flush_o || exc_o || irq_ack_o || ip_o != RV) begin
            n_bad++;
            $display("FAIL R1 reset: cnt=%0d flush=%0b ack=%0b ip=%h exp 0 0 0 %h",
                     commit_cnt, flush_o, irq_ack_o, ip_o, RV);
        end
        rst = 1'b0;
        win_valid = '0; irq_req = 1'b0;

        apply(8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 4'd3, 0, "R6 single not ready");
        apply(8'h01, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 4'd3, 0, "R6 single ready");
        apply(8'h07, 8'h01, 8'h04, 8'h07, 8'h00, 8'h00, 4'd5, 0, "R2 three-entry group");
        apply(8'h07, 8'h01, 8'h04, 8'h05, 8'h00, 8'h00, 4'd5, 0, "R3 middle not ready");
        apply(8'h07, 8'h01, 8'h04, 8'h05, 8'h02, 8'h00, 4'd5, 1, "R5 R10 fault in group");
        apply(8'h1F, 8'h05, 8'h12, 8'h03, 8'h10, 8'h00, 4'd7, 0, "R5 fault beyond group");
        apply(8'hFF, 8'h01, 8'h00, 8'hFF, 8'h00, 8'h00, 4'd1, 0, "R4 no end marker");
        apply(8'h0B, 8'h01, 8'h08, 8'h0B, 8'h00, 8'h00, 4'd1, 0, "R4 hole before end");
        apply(8'h03, 8'h00, 8'h02, 8'h03, 8'h00, 8'h00, 4'd4, 0, "R9 head lacks start");
        apply(8'h03, 8'h01, 8'h02, 8'h03, 8'h00, 8'h00, 4'd15, 1, "R7 irq with retire");
        apply(8'h03, 8'h01, 8'h02, 8'h01, 8'h00, 8'h00, 4'd15, 1, "R7 irq while waiting");
        apply(8'h03, 8'h01, 8'h02, 8'h03, 8'h00, 8'h02, 4'd6, 0, "R8 branch target");
        apply(8'h0F, 8'h01, 8'h08, 8'h0F, 8'h00, 8'h0A, 4'd6, 1, "R8 R7 youngest branch");
        apply(8'hFF, 8'h01, 8'h80, 8'hFF, 8'h00, 8'h00, 4'd9, 0, "R2 full window group");
        apply(8'hFF, 8'h03, 8'h01, 8'h01, 8'hFE, 8'h00, 4'd1, 0, "R6 R5 single ignores rest");
        apply(8'h01, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 4'd15, 0, "R8 max length");
        apply(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 4'd3, 1, "R4 R7 empty window");

        @(negedge clk);
        win_valid = '0; irq_req = 1'b0;
        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule